// File: doc/BRIEF.md
# Multi-Pulse Generator Interrupt Unit

This block gathers the event signals of a motor-drive multi-pulse generator and turns them into sticky interrupt flags and three interrupt request lines. It watches five sources. Two arrive as single-cycle strobes: a write-timing strobe and a position-detect strobe. The block derives the other three itself. A timer compare-clear event is the equality of a 16-bit timer and its compare value. A position compare-match event is the first cycle on which two 3-bit position fields agree. A trip event is a falling edge on an asynchronous trip input, seen after a two-flop synchronizer.

Software uses a small register port. It writes the enable mask, reads back either the mask or the flags, and clears flags by writing 0 to them. Two of the request lines are each shared by a fixed pair of sources. The trip source has a line of its own.

Top module: `mpg_irq_unit`

## Requirements
- R1: After reset all flags and enable bits are 0, all three request lines are low, and reads at either address return 0.
- R2: A write-timing strobe sets flag bit 0 at the next clock edge when enable bit 0 is 1. With enable bit 0 at 0 the strobe leaves the flag at 0.
- R3: On a cycle where timerValue equals compareValue, flag bit 1 is set at the next edge if enable bit 1 is 1.
- R4: A position-detect strobe sets flag bit 2 at the next edge when enable bit 2 is 1.
- R5: Flag bit 3 (compare match) is set only on the first cycle on which expectedPos equals currentPos, and only when enable bit 3 is 1. If the equality is held, the flag does not set again after it has been cleared.
- R6: A high-to-low change on tripIn sets flag bit 4, when enabled, on the third rising edge after the change. Holding tripIn low does not set it again.
- R7: irqWriteClear is the OR of flag AND enable over bits 0 and 1. irqPosMatch is the same over bits 2 and 3. irqTrip is the same for bit 4. Clearing an enable bit masks the line but leaves the flag set.
- R8: A write at regAddr=1 clears each flag whose regWrData bit is 0 and leaves unchanged each flag whose bit is 1. An enabled event on the same cycle as the clearing write keeps its flag set.
- R9: A write at regAddr=0 loads regWrData[4:0] into the enable mask. regRdData returns the enable mask when regAddr=0 and the flags when regAddr=1. An event uses the enable value held before a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrTimingStrobe | input | 1 | Single-cycle write-timing event |
| posDetStrobe | input | 1 | Single-cycle position-detect event |
| timerValue | input | 16 | Current timer count |
| compareValue | input | 16 | Timer compare value |
| expectedPos | input | 3 | Expected position field |
| currentPos | input | 3 | Current position field |
| tripIn | input | 1 | Asynchronous trip input, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = enable mask, 1 = flags |
| regWrData | input | 5 | Write data; bit n is source n |
| regRdData | output | 5 | Read data for regAddr |
| irqWriteClear | output | 1 | Request line for write-timing and compare-clear |
| irqPosMatch | output | 1 | Request line for position-detect and compare-match |
| irqTrip | output | 1 | Request line for the trip source |

## Verification
Most internal state is visible one cycle after it changes. A flag that is lost, stuck or set wrongly appears at the next edge on its request line and in the flag read. A wrong enable bit appears right away in the enable read. A fault in the compare-match edge memory only shows when the equality is held across a flag clear: the flag then comes back in the cycle after the clear, when it should not. A synchronizer of the wrong depth moves the trip flag by one or more edges away from the third edge. Holding tripIn low exposes a detector that fires again.

// File: rtl/mpg_irq_pkg.sv
package mpg_irq_pkg;
  localparam int SRC_N    = 5;
  localparam int SRC_WT   = 0;
  localparam int SRC_CC   = 1;
  localparam int SRC_PD   = 2;
  localparam int SRC_CM   = 3;
  localparam int SRC_TRIP = 4;
  localparam int LINE_N   = 3;

  // Sources feeding each request line
  function automatic logic [SRC_N-1:0] lineMask(input int line);
    logic [SRC_N-1:0] m;
    m = '0;
    case (line)
      0:       begin m[SRC_WT] = 1'b1; m[SRC_CC] = 1'b1; end
      1:       begin m[SRC_PD] = 1'b1; m[SRC_CM] = 1'b1; end
      default: m[SRC_TRIP] = 1'b1;
    endcase
    return m;
  endfunction

  typedef struct packed {
    logic             enLoad;
    logic [SRC_N-1:0] enData;
    logic [SRC_N-1:0] clrMask;
  } regStrobes_t;
endpackage

// File: rtl/mpg_irq_ctrl.sv
module mpg_irq_ctrl
  import mpg_irq_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [SRC_N-1:0] regWrData,
  output regStrobes_t      strobes
);
  always_comb begin
    strobes.enLoad  = regWrEn && !regAddr;
    strobes.enData  = regWrData;
    strobes.clrMask = (regWrEn && regAddr) ? ~regWrData : '0;
  end
endmodule

// File: rtl/mpg_irq_events.sv
module mpg_irq_events
  import mpg_irq_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int POS_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrTimingStrobe,
  input  logic               posDetStrobe,
  input  logic [TIMER_W-1:0] timerValue,
  input  logic [TIMER_W-1:0] compareValue,
  input  logic [POS_W-1:0]   expectedPos,
  input  logic [POS_W-1:0]   currentPos,
  input  logic               tripIn,
  output logic [SRC_N-1:0]   evtVec
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   tripPrev;
  logic                   posEqual;
  logic                   posEqualPrev;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[i] <= 1'b1;
          else       syncChain[i] <= tripIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[i] <= 1'b1;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign posEqual = (expectedPos == currentPos);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripPrev     <= 1'b1;
      posEqualPrev <= 1'b0;
    end else begin
      tripPrev     <= syncChain[LAST];
      posEqualPrev <= posEqual;
    end
  end

  always_comb begin
    evtVec           = '0;
    evtVec[SRC_WT]   = wrTimingStrobe;
    evtVec[SRC_CC]   = (timerValue == compareValue);
    evtVec[SRC_PD]   = posDetStrobe;
    evtVec[SRC_CM]   = posEqual && !posEqualPrev;
    evtVec[SRC_TRIP] = tripPrev && !syncChain[LAST];
  end
endmodule

// File: rtl/mpg_irq_datapath.sv
module mpg_irq_datapath
  import mpg_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [SRC_N-1:0]  evtVec,
  input  logic              regAddr,
  output logic [SRC_N-1:0]  regRdData,
  output logic [SRC_N-1:0]  flagVec,
  output logic [SRC_N-1:0]  enVec,
  output logic [LINE_N-1:0] irqLines
);
  logic [SRC_N-1:0] activeVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagVec <= '0;
      enVec   <= '0;
    end else begin
      flagVec <= (flagVec & ~strobes.clrMask) | (evtVec & enVec);
      if (strobes.enLoad) enVec <= strobes.enData;
    end
  end

  assign activeVec = flagVec & enVec;
  assign regRdData = regAddr ? flagVec : enVec;

  generate
    for (genvar l = 0; l < LINE_N; l++) begin : g_line
      assign irqLines[l] = |(activeVec & lineMask(l));
    end
  endgenerate
endmodule

// File: rtl/mpg_irq_unit.sv
module mpg_irq_unit
  import mpg_irq_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int POS_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrTimingStrobe,
  input  logic               posDetStrobe,
  input  logic [TIMER_W-1:0] timerValue,
  input  logic [TIMER_W-1:0] compareValue,
  input  logic [POS_W-1:0]   expectedPos,
  input  logic [POS_W-1:0]   currentPos,
  input  logic               tripIn,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [4:0]         regWrData,
  output logic [4:0]         regRdData,
  output logic               irqWriteClear,
  output logic               irqPosMatch,
  output logic               irqTrip
);
  regStrobes_t       strobes;
  logic [SRC_N-1:0]  evtVec;
  logic [SRC_N-1:0]  flagVec;
  logic [SRC_N-1:0]  enVec;
  logic [LINE_N-1:0] irqLines;

  mpg_irq_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  mpg_irq_events #(
    .TIMER_W    (TIMER_W),
    .POS_W      (POS_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_events (
    .clk           (clk),
    .rstN          (rstN),
    .wrTimingStrobe(wrTimingStrobe),
    .posDetStrobe  (posDetStrobe),
    .timerValue    (timerValue),
    .compareValue  (compareValue),
    .expectedPos   (expectedPos),
    .currentPos    (currentPos),
    .tripIn        (tripIn),
    .evtVec        (evtVec)
  );

  mpg_irq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .evtVec   (evtVec),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .flagVec  (flagVec),
    .enVec    (enVec),
    .irqLines (irqLines)
  );

  assign irqWriteClear = irqLines[0];
  assign irqPosMatch   = irqLines[1];
  assign irqTrip       = irqLines[2];
endmodule

// File: rtl/mpg_irq_checker.sv
module mpg_irq_checker #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrTimingStrobe,
  input logic [TIMER_W-1:0] timerValue,
  input logic [TIMER_W-1:0] compareValue,
  input logic               regWrEn,
  input logic               regAddr,
  input logic [4:0]         regWrData,
  input logic [4:0]         evtVec,
  input logic [4:0]         flagVec,
  input logic [4:0]         enVec,
  input logic               irqWriteClear,
  input logic               irqPosMatch,
  input logic               irqTrip
);
  p_wt_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrTimingStrobe && enVec[0] |=> flagVec[0]);

  p_cc_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (timerValue == compareValue) && enVec[1] |=> flagVec[1]);

  p_trip_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    evtVec[4] |=> !evtVec[4]);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == 5'b0) |-> !(irqWriteClear || irqPosMatch || irqTrip));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr && !regWrData[0] && !wrTimingStrobe |=> !flagVec[0]);
endmodule

bind mpg_irq_unit mpg_irq_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrTimingStrobe(wrTimingStrobe),
  .timerValue    (timerValue),
  .compareValue  (compareValue),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .evtVec        (evtVec),
  .flagVec       (flagVec),
  .enVec         (enVec),
  .irqWriteClear (irqWriteClear),
  .irqPosMatch   (irqPosMatch),
  .irqTrip       (irqTrip)
);

// File: tb/mpg_irq_unit_test.sv
`timescale 1ns/100ps
module mpg_irq_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrTimingStrobe = 1'b0, posDetStrobe = 1'b0;
  logic [15:0] timerValue = 16'h0001, compareValue = 16'h8000;
  logic [2:0]  expectedPos = 3'd1, currentPos = 3'd2;
  logic        tripIn = 1'b1;
  logic        regWrEn = 1'b0, regAddr = 1'b0;
  logic [4:0]  regWrData = 5'b0;
  logic [4:0]  regRdData;
  logic        irqWriteClear, irqPosMatch, irqTrip;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [4:0] mFlag, mEn;
  logic       mEqPrev, mS1, mS2, mPrev;

  always #2.5 clk = ~clk;

  mpg_irq_unit uut (
    .clk(clk), .rstN(rstN), .wrTimingStrobe(wrTimingStrobe),
    .posDetStrobe(posDetStrobe), .timerValue(timerValue),
    .compareValue(compareValue), .expectedPos(expectedPos),
    .currentPos(currentPos), .tripIn(tripIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqWriteClear(irqWriteClear), .irqPosMatch(irqPosMatch), .irqTrip(irqTrip)
  );

  task automatic modelReset();
    mFlag = '0; mEn = '0; mEqPrev = 1'b0; mS1 = 1'b1; mS2 = 1'b1; mPrev = 1'b1;
  endtask

  // one clock edge of the requirement model, using the inputs held before it
  task automatic modelEdge();
    logic [4:0] evt, clr;
    logic eq;
    eq = (expectedPos == currentPos);
    evt = {mPrev && !mS2, eq && !mEqPrev, posDetStrobe,
           timerValue == compareValue, wrTimingStrobe};
    clr = (regWrEn && regAddr) ? ~regWrData : 5'b0;
    mFlag = (mFlag & ~clr) | (evt & mEn);
    if (regWrEn && !regAddr) mEn = regWrData;
    mEqPrev = eq;
    mPrev = mS2; mS2 = mS1; mS1 = tripIn;
  endtask

  function automatic logic [2:0] expLines();
    logic [4:0] a;
    a = mFlag & mEn;
    return {a[4], a[3] | a[2], a[1] | a[0]};
  endfunction

  task automatic compareNow(input string tag);
    logic [4:0] rd;
    rd = regAddr ? mFlag : mEn;
    checks++;
    if ({irqTrip, irqPosMatch, irqWriteClear} !== expLines() || regRdData !== rd) begin
      failures++;
      $display("FAIL %s irq=%b exp=%b rd=%b exp=%b", tag,
               {irqTrip, irqPosMatch, irqWriteClear}, expLines(), regRdData, rd);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    #1;
    compareNow(tag);
    @(negedge clk);
    wrTimingStrobe = 1'b0; posDetStrobe = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic expectBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [4:0] d, input string tag);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(tag);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    #1;
    compareNow("R1 reset");
    regAddr = 1'b1; #1; compareNow("R1 reset flags");
    rstN = 1'b1;
    @(negedge clk);

    // R2 disabled strobe then enabled strobe
    wrTimingStrobe = 1'b1; step("R2 disabled");
    regAddr = 1'b1; #1; expectBit("R2 flag stays 0", regRdData[0], 1'b0);
    writeReg(1'b0, 5'b11111, "R9 enable load");
    regAddr = 1'b0; #1; expectBit("R9 enable readback", regRdData == 5'b11111, 1'b1);
    wrTimingStrobe = 1'b1; step("R2 enabled");
    expectBit("R2 irqWriteClear", irqWriteClear, 1'b1);
    // R8 clear with simultaneous event keeps flag
    wrTimingStrobe = 1'b1; writeReg(1'b1, 5'b11110, "R8 event wins");
    expectBit("R8 flag kept", regRdData[0], 1'b1);
    writeReg(1'b1, 5'b11110, "R8 clear");
    expectBit("R8 flag cleared", irqWriteClear, 1'b0);

    // R3 timer compare
    timerValue = 16'h1234; compareValue = 16'h1234; step("R3 equal");
    timerValue = 16'h0; step("R3 hold");
    expectBit("R3 irqWriteClear", irqWriteClear, 1'b1);
    writeReg(1'b1, 5'b00000, "R8 clear all");

    // R4 position detect
    posDetStrobe = 1'b1; step("R4 strobe");
    expectBit("R4 irqPosMatch", irqPosMatch, 1'b1);
    // R7 masking keeps flag
    writeReg(1'b0, 5'b11011, "R7 mask bit2");
    expectBit("R7 line masked", irqPosMatch, 1'b0);
    regAddr = 1'b1; #1; expectBit("R7 flag kept", regRdData[2], 1'b1);
    writeReg(1'b0, 5'b11111, "R7 unmask");
    expectBit("R7 line back", irqPosMatch, 1'b1);
    writeReg(1'b1, 5'b00000, "R8 clear all");

    // R5 compare match edge only
    expectedPos = 3'd5; currentPos = 3'd5; step("R5 first equal");
    expectBit("R5 set", irqPosMatch, 1'b1);
    writeReg(1'b1, 5'b10111, "R5 clear while equal");
    step("R5 sustained");
    expectBit("R5 no retrigger", irqPosMatch, 1'b0);
    currentPos = 3'd4; step("R5 unequal");
    currentPos = 3'd5; step("R5 equal again");
    expectBit("R5 retrigger on new edge", irqPosMatch, 1'b1);
    writeReg(1'b1, 5'b00000, "R8 clear all");

    // R6 trip: third edge after the fall
    tripIn = 1'b0;
    step("R6 edge1"); expectBit("R6 not yet 1", irqTrip, 1'b0);
    step("R6 edge2"); expectBit("R6 not yet 2", irqTrip, 1'b0);
    step("R6 edge3"); expectBit("R6 set at edge3", irqTrip, 1'b1);
    writeReg(1'b1, 5'b00000, "R6 clear");
    repeat (4) step("R6 held low");
    expectBit("R6 no retrigger", irqTrip, 1'b0);
    tripIn = 1'b1;
    repeat (4) step("R6 release");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      wrTimingStrobe = ($urandom % 6) == 0;
      posDetStrobe   = ($urandom % 6) == 0;
      timerValue     = 16'($urandom);
      if (($urandom % 8) == 0) compareValue = timerValue;
      else compareValue = 16'($urandom);
      expectedPos    = 3'($urandom);
      currentPos     = 3'($urandom);
      if (($urandom % 10) == 0) tripIn = ~tripIn;
      regWrEn   = ($urandom % 5) == 0;
      regAddr   = 1'($urandom);
      regWrData = 5'($urandom);
      @(posedge clk);
      modelEdge();
      #1;
      compareNow("R7 R9 random");
      @(negedge clk);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7341);
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule